// File: doc/BRIEF.md
# Channel-Pair Fault Shutdown and Retry Controller

This block protects one pair of power half-bridge channels. It watches per-channel over-current events, a shared over-temperature event, a supply under-voltage event and a thermal-warning level. It decides when the pair's outputs go to high impedance and when they may switch again. It also drives three active-low error flags for the system controller.

A static mode input selects between two shutdown policies. In latched shutdown the pair stays off until the fault is gone and the channel reset has been pulled low and released. In auto-retry the block waits a fixed interval, then tries to re-enable. It repeats this a bounded number of times, and after the last failure it falls back to the latch, which only a channel reset cycle clears. All event and reset inputs are asynchronous to the block clock and are brought in through two-flop synchronisers.

Top module: `pair_fault_ctrl`

## Requirements
- R1: An over-current on either channel, an over-temperature or an under-voltage forces `hiz_o` high on the third clock edge after the input rises.
- R2: While `chan_rst_ni` is low, `hiz_o` is high and the attempt count is cleared. Once it is high again with no fault, `hiz_o` falls on the third clock edge after the release.
- R3: With `retry_mode_i` = 1 (auto-retry), if the fault has cleared, `hiz_o` falls exactly `RETRY_CYC` cycles after the shutdown edge.
- R4: If a fault is still present at a retry point, the outputs stay off and the next attempt follows `RETRY_CYC` cycles later. A successful re-enable clears the attempt count.
- R5: After `MAX_TRIES` consecutive failed attempts in auto-retry, the pair stays off even after the fault clears, until a channel reset cycle.
- R6: With `retry_mode_i` = 0 (latched), a fault keeps the pair off after the fault clears, until `chan_rst_ni` goes low and then high.
- R7: A new rising edge of the synchronised fault during the retry wait restarts the interval. The next attempt is then `RETRY_CYC` cycles after that edge.
- R8: `oc_err_no` is low while either bit of `oc_i` is high. Bit 0 is channel A and bit 1 is channel B.
- R9: `warn_no` is low while `warn_i` is high. A warning alone never sets `hiz_o`.
- R10: `tuv_err_no` is low while `ot_i` or `uv_i` is high. The pair (`warn_no`,`tuv_err_no`) reads 11 for normal, 01 for warning only, 10 for error only, and 00 for warning plus error.
- R11: Every flag follows its input with a latency of two clock edges. Under `rst_ni` low, all flags are high and `hiz_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_rst_ni | input | 1 | Active-low channel-pair reset (asynchronous level) |
| retry_mode_i | input | 1 | 1 = auto-retry, 0 = latched shutdown (static) |
| oc_i | input | 2 | Over-current events, bit 0 channel A, bit 1 channel B |
| ot_i | input | 1 | Over-temperature event |
| uv_i | input | 1 | Supply under-voltage event |
| warn_i | input | 1 | Thermal-warning level |
| hiz_o | output | 1 | 1 = pair outputs held at high impedance |
| oc_err_no | output | 1 | Active-low over-current flag for the pair |
| tuv_err_no | output | 1 | Active-low thermal/under-voltage error flag |
| warn_no | output | 1 | Active-low thermal-warning flag |

## Verification
The flags are combinational from the synchroniser outputs, so they are due two edges after an input change. `hiz_o` comes from the state register behind the synchroniser and is due three edges after a fault or channel-reset change. Retry decisions fall exactly `RETRY_CYC` edges after the shutdown edge, or after the last restarting fault edge. The bench drives inputs on falling edges and counts falling edges from each stimulus. It samples `hiz_o` one edge before and exactly at each computed decision edge, so an off-by-one in the timer or in the attempt count shows up as a wrong level.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LATCH = 2'd3
  } fg_state_e;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/fg_retry_ctrl.sv
module fg_retry_ctrl
  import fg_pkg::*;
#(
  parameter int RETRY_CYC = 8500000,
  parameter int MAX_TRIES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic chan_on_i,
  input  logic retry_mode_i,
  output logic hiz_o
);
  localparam int TW = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(RETRY_CYC - 1);
  localparam logic [CW-1:0] N_LAST = CW'(MAX_TRIES - 1);

  fg_state_e     state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [CW-1:0] tries_q, tries_d;
  logic          fault_q;
  logic          fault_rise;

  assign fault_rise = fault_i & ~fault_q;

  always_comb begin
    state_d = state_q;
    timer_d = timer_q;
    tries_d = tries_q;
    if (!chan_on_i) begin
      state_d = ST_OFF;
      timer_d = '0;
      tries_d = '0;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_RUN;
        ST_RUN: if (fault_i) begin
          timer_d = '0;
          state_d = retry_mode_i ? ST_WAIT : ST_LATCH;
        end
        ST_WAIT: begin
          if (fault_rise) begin
            timer_d = '0;  // fresh fault edge restarts the interval
          end else if (timer_q == T_LAST) begin
            timer_d = '0;
            if (!fault_i) begin
              state_d = ST_RUN;
              tries_d = '0;
            end else if (tries_q == N_LAST) begin
              state_d = ST_LATCH;
            end else begin
              tries_d = tries_q + 1'b1;
            end
          end else begin
            timer_d = timer_q + 1'b1;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      timer_q <= '0;
      tries_q <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      tries_q <= tries_d;
      fault_q <= fault_i;
    end
  end

  assign hiz_o = (state_q != ST_RUN);

  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && state_q == ST_RUN && chan_on_i) |=> (state_q != ST_RUN)); // R1
  AST_TIMER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (timer_q <= T_LAST)); // R3
  AST_RECOVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_WAIT) |-> (tries_q == '0)); // R4
  AST_TRIES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (tries_q < CW'(MAX_TRIES))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && chan_on_i) |=> (state_q == ST_LATCH)); // R6
endmodule

// File: rtl/pair_fault_ctrl.sv
module pair_fault_ctrl #(
  parameter int RETRY_CYC   = 8500000,
  parameter int MAX_TRIES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_rst_ni,
  input  logic       retry_mode_i,
  input  logic [1:0] oc_i,
  input  logic       ot_i,
  input  logic       uv_i,
  input  logic       warn_i,
  output logic       hiz_o,
  output logic       oc_err_no,
  output logic       tuv_err_no,
  output logic       warn_no
);
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] raw, syn;
  logic             oc_s, ot_s, uv_s, warn_s, chan_on_s, fault_s;

  assign raw = {chan_rst_ni, warn_i, uv_i, ot_i, oc_i};

  fg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign oc_s      = |syn[1:0];
  assign ot_s      = syn[2];
  assign uv_s      = syn[3];
  assign warn_s    = syn[4];
  assign chan_on_s = syn[5];
  assign fault_s   = oc_s | ot_s | uv_s;

  fg_retry_ctrl #(.RETRY_CYC(RETRY_CYC), .MAX_TRIES(MAX_TRIES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (fault_s),
    .chan_on_i   (chan_on_s),
    .retry_mode_i(retry_mode_i),
    .hiz_o       (hiz_o)
  );

  assign oc_err_no  = ~oc_s;
  assign tuv_err_no = ~(ot_s | uv_s);
  assign warn_no    = ~warn_s;

  AST_CHAN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_on_s |=> hiz_o); // R2
endmodule

// File: tb/pair_fault_ctrl_tb_top.sv
module pair_fault_ctrl_tb_top;
  localparam int RC = 16;
  localparam int MT = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chan_rst_ni = 1'b0;
  logic       retry_mode_i = 1'b1;
  logic [1:0] oc_i = 2'b00;
  logic       ot_i = 1'b0, uv_i = 1'b0, warn_i = 1'b0;
  logic       hiz_o, oc_err_no, tuv_err_no, warn_no;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pair_fault_ctrl #(.RETRY_CYC(RC), .MAX_TRIES(MT), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .chan_rst_ni(chan_rst_ni),
    .retry_mode_i(retry_mode_i), .oc_i(oc_i), .ot_i(ot_i), .uv_i(uv_i),
    .warn_i(warn_i), .hiz_o(hiz_o), .oc_err_no(oc_err_no),
    .tuv_err_no(tuv_err_no), .warn_no(warn_no)
  );

  // {oc[1:0], ot, uv, warn, exp oc_n, exp tuv_n, exp warn_n}
  localparam logic [7:0] VEC [11] = '{
    8'b00000_111, 8'b01000_011, 8'b10000_011, 8'b11000_011,
    8'b00100_101, 8'b00010_101, 8'b00001_110, 8'b00101_100,
    8'b00011_100, 8'b00111_100, 8'b01001_010
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic chan_cycle();
    chan_rst_ni = 1'b0;
    step(4);
    chan_rst_ni = 1'b1;
    step(4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    // R11 reset state
    chk("R11 hiz in reset", hiz_o, 1'b1);
    chk("R11 oc flag in reset", oc_err_no, 1'b1);
    chk("R11 tuv flag in reset", tuv_err_no, 1'b1);
    chk("R11 warn flag in reset", warn_no, 1'b1);
    rst_ni = 1'b1;
    step(2);
    chk("R2 off while chan reset low", hiz_o, 1'b1);
    chan_rst_ni = 1'b1;
    step(2);
    chk("R2 still off before third edge", hiz_o, 1'b1);
    step(1);
    chk("R2 run after release", hiz_o, 1'b0);

    // R8 R10 R11 flag table
    for (int i = 0; i < 11; i++) begin
      {oc_i, ot_i, uv_i, warn_i} = VEC[i][7:3];
      step(1);
      chk("R11 flag latency", oc_err_no, (i == 0) ? 1'b1 : ((VEC[i-1][7:6] != 0) ? 1'b0 : 1'b1));
      step(1);
      chk("R8 oc flag", oc_err_no, VEC[i][2]);
      chk("R10 tuv flag", tuv_err_no, VEC[i][1]);
      chk("R9 warn flag", warn_no, VEC[i][0]);
    end
    {oc_i, ot_i, uv_i, warn_i} = '0;
    step(2);
    chan_cycle();
    chk("R2 clean run after chan cycle", hiz_o, 1'b0);

    // R9 warning alone
    warn_i = 1'b1;
    step(8);
    chk("R9 warning no shutdown", hiz_o, 1'b0);
    warn_i = 1'b0;
    step(2);

    // R1 R3 single retry success, oc on channel B
    oc_i = 2'b10;
    step(2);
    chk("R1 not yet off", hiz_o, 1'b0);
    step(1);
    chk("R1 off on third edge", hiz_o, 1'b1);
    step(1);
    oc_i = 2'b00;           // t=4
    step(3 + RC - 1 - 4);
    chk("R3 off one before interval", hiz_o, 1'b1);
    step(1);
    chk("R3 re-enable at interval", hiz_o, 1'b0);
    step(4);

    // R4 two failures then success at third attempt
    ot_i = 1'b1;
    step(3 + 2 * RC + 4);
    ot_i = 1'b0;            // t=39
    step(3 + 3 * RC - 1 - 39);
    chk("R4 off before third attempt", hiz_o, 1'b1);
    step(1);
    chk("R4 recover at third attempt", hiz_o, 1'b0);
    step(4);

    // R4 counter cleared: four failures then success at fifth attempt
    uv_i = 1'b1;
    step(3 + 4 * RC + 4);
    uv_i = 1'b0;            // t=71
    step(3 + 5 * RC - 1 - 71);
    chk("R4 off before fifth attempt", hiz_o, 1'b1);
    step(1);
    chk("R4 count cleared, fifth succeeds", hiz_o, 1'b0);
    step(4);

    // R5 five failures latch
    oc_i = 2'b01;
    step(3 + 5 * RC + 4);
    oc_i = 2'b00;
    step(3 * RC);
    chk("R5 latched after max tries", hiz_o, 1'b1);
    chan_rst_ni = 1'b0;
    step(3);
    chk("R2 off in chan reset", hiz_o, 1'b1);
    chan_rst_ni = 1'b1;
    step(3);
    chk("R5 latch cleared by chan cycle", hiz_o, 1'b0);
    step(2);

    // R7 restart on new fault edge
    ot_i = 1'b1;
    step(2);
    ot_i = 1'b0;
    step(6);
    ot_i = 1'b1;            // t=8
    step(2);
    ot_i = 1'b0;            // t=10
    step(10);               // t=20, past original deadline 19
    chk("R7 no retry at original deadline", hiz_o, 1'b1);
    step(6);                // t=26
    chk("R7 off before restarted deadline", hiz_o, 1'b1);
    step(1);                // t=27
    chk("R7 re-enable after restart", hiz_o, 1'b0);
    step(4);

    // R6 latched mode
    retry_mode_i = 1'b0;
    uv_i = 1'b1;
    step(3);
    chk("R6 off on fault", hiz_o, 1'b1);
    uv_i = 1'b0;
    step(3 * RC);
    chk("R6 stays off after fault clears", hiz_o, 1'b1);
    chan_cycle();
    chk("R6 cleared by chan cycle", hiz_o, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule